// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This block sits between a processor register port and an SPI serial engine. It holds two byte-wide queues of 32 entries, one for outgoing and one for incoming data. Software fills the outgoing queue and drains the incoming queue through a single data port. Each access can be 8, 16 or 32 bits wide, and bytes move in big-endian order. The serial engine takes outgoing bytes and loads incoming bytes through single-byte handshakes, and it reports the end of a transaction with a one-cycle pulse.

Status is gathered into one event word. The word holds live occupancy fields and live level flags, and it also holds four sticky flags that software clears by writing ones. A mask register uses the same bit positions. The interrupt line is the OR of the event flags that are enabled in the mask. A mode word holds a receive threshold and a transmit threshold.

Register select codes: 0 is the mode word, 1 is the event word, 2 is the mask word and 3 is the data port. Size codes: 0 is one byte, 1 is two bytes, and 2 or 3 is four bytes.

Top module: `spi_fifo_evt`

## Requirements
- R1: After reset, the event word reads 0x0020_8900 once the first clock has passed: transmit free is 32, the transmit-empty, transmit-threshold and transmit-not-full flags are set, and everything else is clear. The mask reads 0 and the irq output is low.
- R2: A data-port write of four bytes queues bits 31:24, 23:16, 15:8 and 7:0, in that order. A two-byte write queues bits 15:8 and then bits 7:0. A one-byte write queues bits 7:0. The engine receives the bytes in queue order on tx_byte while tx_valid is high, and tx_take removes one byte.
- R3: A data-port read removes 1, 2 or 4 bytes. The oldest byte lands in the top byte of the access width: bits 31:24 for four bytes, bits 15:8 for two bytes and bits 7:0 for one byte. Unused upper bits read 0.
- R4: Event bits 29:24 give the receive occupancy and bits 21:16 give the transmit free space. Both follow the queues without any clearing.
- R5: The live flags sit at these positions: transmit empty at bit 15, receive not-empty at bit 9 and transmit not-full at bit 8.
- R6: The sticky flags sit at these positions: done at bit 14 (set by xfer_done), receive threshold at bit 13 (set while receive occupancy is greater than the receive threshold), receive full at bit 12 (set while the receive queue holds 32 bytes) and transmit threshold at bit 11 (set while transmit occupancy is below the transmit threshold). Each stays set after its cause goes away. A set condition wins over a clear in the same cycle.
- R7: Writing the event word clears each sticky flag whose bit is written as 1. Bits written as 0 leave their flags unchanged. Writing all ones clears every sticky flag whose cause is absent.
- R8: The mask word holds enables at bits 15:11, 9 and 8. Bit 10 and all other bits read 0. irq is high exactly when some event flag and its enable are both set.
- R9: A data-port write whose bytes do not all fit in the transmit queue is ignored entirely. A receive load while the receive queue is full is dropped.
- R10: A data-port read that asks for more bytes than the receive queue holds returns 0 and removes nothing.
- R11: The mode word keeps the transmit threshold in bits 13:8 and the receive threshold in bits 5:0. It resets to 0x0000_040F, and a write takes effect for the sticky-flag conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 for write, 0 for read |
| acc_reg | input | 2 | Register select |
| acc_size | input | 2 | Data-port access width |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid in the cycle of the access |
| tx_valid | output | 1 | Transmit queue holds a byte |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_take | input | 1 | Engine removes one transmit byte |
| rx_load | input | 1 | Engine delivers one received byte |
| rx_byte | input | 8 | Received byte |
| xfer_done | input | 1 | End-of-transaction pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that tx_take is raised only while tx_valid is high. They also assume that register strobes last one cycle, so a read of the data port removes bytes only once. The bench raises tx_take only while draining bytes its scoreboard expects, and it releases every strobe one clock after raising it. Sticky flags appear one clock after the occupancy change that causes them, so the bench idles two clocks before sampling them.

// File: rtl/spi_fifo_evt.sv
module spi_fifo_evt #(
  parameter int DEPTH     = 32,
  parameter int TXTHR_RST = 4,
  parameter int RXTHR_RST = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_en,
  input  logic        acc_wr,
  input  logic [1:0]  acc_reg,
  input  logic [1:0]  acc_size,
  input  logic [31:0] acc_wdata,
  output logic [31:0] acc_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  input  logic        tx_take,
  input  logic        rx_load,
  input  logic [7:0]  rx_byte,
  input  logic        xfer_done,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [7:0]    tmem [DEPTH];
  logic [7:0]    rmem [DEPTH];
  logic [AW-1:0] twp, trp, rwp, rrp;
  logic [CW-1:0] tcnt, rcnt;
  logic [5:0]    tx_thr, rx_thr;
  logic [7:0]    msk;
  logic          ev_don, ev_rxt, ev_rxf, ev_txt;

  logic [2:0]    nb;
  logic [7:0]    pb [4];
  logic [7:0]    rb [4];
  logic [31:0]   rd_word;

  always_comb begin
    case (acc_size)
      2'd0:    nb = 3'd1;
      2'd1:    nb = 3'd2;
      default: nb = 3'd4;
    endcase
  end

  always_comb begin
    case (acc_size)
      2'd0:    pb = '{acc_wdata[7:0], 8'h00, 8'h00, 8'h00};
      2'd1:    pb = '{acc_wdata[15:8], acc_wdata[7:0], 8'h00, 8'h00};
      default: pb = '{acc_wdata[31:24], acc_wdata[23:16], acc_wdata[15:8], acc_wdata[7:0]};
    endcase
  end

  wire port_wr = acc_en &  acc_wr & (acc_reg == 2'd3);
  wire port_rd = acc_en & ~acc_wr & (acc_reg == 2'd3);
  wire mode_wr = acc_en &  acc_wr & (acc_reg == 2'd0);
  wire evt_wr  = acc_en &  acc_wr & (acc_reg == 2'd1);
  wire mask_wr = acc_en &  acc_wr & (acc_reg == 2'd2);

  wire tx_push = port_wr && (({1'b0, tcnt} + (CW+1)'(nb)) <= (CW+1)'(DEPTH));
  wire tx_pop  = tx_take && (tcnt != '0);
  wire rx_ok   = ({1'b0, rcnt} >= (CW+1)'(nb));
  wire rx_pop  = port_rd && rx_ok;
  wire rx_in   = rx_load && (rcnt != CW'(DEPTH));

  assign tx_valid = (tcnt != '0);
  assign tx_byte  = tmem[trp];

  always_ff @(posedge clk) begin
    if (tx_push)
      for (int k = 0; k < 4; k++)
        if (k < int'(nb)) tmem[twp + AW'(k)] <= pb[k];
    if (rx_in) rmem[rwp] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      twp  <= '0;
      trp  <= '0;
      tcnt <= '0;
      rwp  <= '0;
      rrp  <= '0;
      rcnt <= '0;
    end else begin
      if (tx_push) twp <= twp + AW'(nb);
      if (tx_pop)  trp <= trp + 1'b1;
      tcnt <= tcnt + (tx_push ? CW'(nb) : '0) - (tx_pop ? CW'(1) : '0);
      if (rx_in)  rwp <= rwp + 1'b1;
      if (rx_pop) rrp <= rrp + AW'(nb);
      rcnt <= rcnt + (rx_in ? CW'(1) : '0) - (rx_pop ? CW'(nb) : '0);
    end
  end

  always_comb
    for (int k = 0; k < 4; k++) rb[k] = rmem[rrp + AW'(k)];

  always_comb begin
    case (acc_size)
      2'd0:    rd_word = {24'h0, rb[0]};
      2'd1:    rd_word = {16'h0, rb[0], rb[1]};
      default: rd_word = {rb[0], rb[1], rb[2], rb[3]};
    endcase
  end

  wire set_rxt = (7'(rcnt) > 7'(rx_thr));
  wire set_txt = (7'(tcnt) < 7'(tx_thr));
  wire set_rxf = (rcnt == CW'(DEPTH));
  wire [31:0] clr = evt_wr ? acc_wdata : 32'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_thr <= 6'(TXTHR_RST);
      rx_thr <= 6'(RXTHR_RST);
      msk    <= '0;
      ev_don <= 1'b0;
      ev_rxt <= 1'b0;
      ev_rxf <= 1'b0;
      ev_txt <= 1'b0;
    end else begin
      if (mode_wr) begin
        tx_thr <= acc_wdata[13:8];
        rx_thr <= acc_wdata[5:0];
      end
      if (mask_wr) msk <= acc_wdata[15:8] & 8'hFB;
      ev_don <= xfer_done | (ev_don & ~clr[14]);
      ev_rxt <= set_rxt   | (ev_rxt & ~clr[13]);
      ev_rxf <= set_rxf   | (ev_rxf & ~clr[12]);
      ev_txt <= set_txt   | (ev_txt & ~clr[11]);
    end
  end

  wire [5:0] rx_fill = 6'(rcnt);
  wire [5:0] tx_free = 6'(CW'(DEPTH) - tcnt);
  wire [7:0] flags   = {tcnt == '0, ev_don, ev_rxt, ev_rxf, ev_txt, 1'b0,
                        rcnt != '0, tcnt != CW'(DEPTH)};

  assign irq = |(flags & msk);

  always_comb begin
    case (acc_reg)
      2'd0:    acc_rdata = {18'h0, tx_thr, 2'b00, rx_thr};
      2'd1:    acc_rdata = {2'b00, rx_fill, 2'b00, tx_free, flags, 8'h00};
      2'd2:    acc_rdata = {16'h0, msk, 8'h00};
      default: acc_rdata = rx_ok ? rd_word : 32'h0;
    endcase
  end
endmodule

module spi_fifo_evt_chk #(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_en,
  input logic          acc_wr,
  input logic [1:0]    acc_reg,
  input logic [31:0]   acc_wdata,
  input logic [31:0]   acc_rdata,
  input logic          tx_valid,
  input logic          tx_take,
  input logic          xfer_done,
  input logic          irq,
  input logic [CW-1:0] tcnt,
  input logic [CW-1:0] rcnt,
  input logic          ev_don,
  input logic [7:0]    msk
);
  wire push_req = acc_en & acc_wr & (acc_reg == 2'd3);
  wire pop_req  = acc_en & ~acc_wr & (acc_reg == 2'd3);
  wire don_clr  = acc_en & acc_wr & (acc_reg == 2'd1) & acc_wdata[14];

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt <= CW'(DEPTH)) && (rcnt <= CW'(DEPTH)));

  a_r9_tx_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt == CW'(DEPTH) && push_req && !tx_take) |=> (tcnt == CW'(DEPTH)));

  a_r10_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rcnt == '0 && pop_req) |-> (acc_rdata == 32'h0));

  a_r6_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> ev_don);

  a_r6_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_don && !don_clr) |=> ev_don);

  a_r8_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (msk == 8'h00) |-> !irq);

  a_r2_empty_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt == '0) |-> !tx_valid);
endmodule

bind spi_fifo_evt spi_fifo_evt_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
  .acc_reg(acc_reg), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
  .tx_valid(tx_valid), .tx_take(tx_take), .xfer_done(xfer_done),
  .irq(irq), .tcnt(tcnt), .rcnt(rcnt), .ev_don(ev_don), .msk(msk)
);

// File: tb/spi_fifo_evt_test.sv
module spi_fifo_evt_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_wr = 1'b0;
  logic [1:0]  acc_reg = 2'd0, acc_size = 2'd0;
  logic [31:0] acc_wdata = 32'h0;
  logic [31:0] acc_rdata;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        tx_take = 1'b0, rx_load = 1'b0, xfer_done = 1'b0;
  logic [7:0]  rx_byte = 8'h0;
  logic        irq;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [31:0] rv;

  always #4 clk = ~clk;

  spi_fifo_evt uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] r, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_reg = r; acc_size = sz; acc_wdata = wd;
    #1 rd = acc_rdata;
    @(posedge clk);
    #1 acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic wr_reg(input logic [1:0] r, input logic [31:0] wd);
    logic [31:0] d;
    access(1'b1, r, 2'd2, wd, d);
  endtask

  task automatic rd_reg(input logic [1:0] r, output logic [31:0] d);
    access(1'b0, r, 2'd2, 32'h0, d);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic push_tx(input logic [1:0] sz, input logic [31:0] wd);
    int n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    logic [31:0] d;
    if (txq.size() + n <= 32)
      for (int k = n - 1; k >= 0; k--) txq.push_back(wd[8*k +: 8]);
    access(1'b1, 2'd3, sz, wd, d);
  endtask

  task automatic drain_tx(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, {31'h0, tx_valid}, 32'h1);
      check(req, {24'h0, tx_byte}, {24'h0, txq.pop_front()});
      tx_take = 1'b1;
      @(posedge clk);
      #1 tx_take = 1'b0;
    end
  endtask

  task automatic load_rx(input logic [7:0] b);
    @(negedge clk);
    if (rxq.size() < 32) rxq.push_back(b);
    rx_load = 1'b1; rx_byte = b;
    @(posedge clk);
    #1 rx_load = 1'b0;
  endtask

  task automatic read_rx(input string req, input logic [1:0] sz);
    int n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    logic [31:0] exp = 32'h0;
    logic [31:0] d;
    if (rxq.size() >= n)
      for (int k = n - 1; k >= 0; k--) exp[8*k +: 8] = rxq.pop_front();
    access(1'b0, 2'd3, sz, 32'h0, d);
    check(req, d, exp);
  endtask

  task automatic pulse_done;
    @(negedge clk);
    xfer_done = 1'b1;
    @(posedge clk);
    #1 xfer_done = 1'b0;
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    rd_reg(2'd1, rv); check("R1 event reset", rv, 32'h0020_8900);
    rd_reg(2'd2, rv); check("R1 mask reset", rv, 32'h0);
    check("R1 irq reset", {31'h0, irq}, 32'h0);
    rd_reg(2'd0, rv); check("R11 mode reset", rv, 32'h0000_040F);

    push_tx(2'd2, 32'hA1B2C3D4);
    push_tx(2'd1, 32'h1234E5F6);
    push_tx(2'd0, 32'hFFFFFF77);
    rd_reg(2'd1, rv);
    check("R4 tx free", {26'h0, rv[21:16]}, 32'd25);
    check("R5 tx empty clear", {31'h0, rv[15]}, 32'h0);
    drain_tx("R2 tx order", 7);
    rd_reg(2'd1, rv);
    check("R4 tx free after drain", {26'h0, rv[21:16]}, 32'd32);
    check("R5 tx empty set", {31'h0, rv[15]}, 32'h1);

    for (int i = 0; i < 7; i++) push_tx(2'd2, 32'h01020304 + 32'h10101010 * i);
    push_tx(2'd1, 32'h0000ABCD);
    push_tx(2'd0, 32'h000000EF);
    push_tx(2'd1, 32'h00005A5A);
    push_tx(2'd0, 32'h00000042);
    push_tx(2'd2, 32'hDEADBEEF);
    rd_reg(2'd1, rv);
    check("R9 tx full free", {26'h0, rv[21:16]}, 32'd0);
    check("R5 tx not-full clear", {31'h0, rv[8]}, 32'h0);
    drain_tx("R9 tx overflow ignored", 32);
    check("R2 tx empty invalid", {31'h0, tx_valid}, 32'h0);

    foreach (rv[i]) if (i < 7) load_rx(8'h11 * (i + 1));
    rd_reg(2'd1, rv);
    check("R4 rx fill", {26'h0, rv[29:24]}, 32'd7);
    check("R5 rx not-empty", {31'h0, rv[9]}, 32'h1);
    read_rx("R3 rx word", 2'd2);
    read_rx("R3 rx half", 2'd1);
    read_rx("R3 rx byte", 2'd0);
    read_rx("R10 rx empty byte", 2'd0);
    load_rx(8'h99);
    read_rx("R10 rx short half", 2'd1);
    rd_reg(2'd1, rv);
    check("R10 rx not popped", {26'h0, rv[29:24]}, 32'd1);
    read_rx("R3 rx single", 2'd0);

    wr_reg(2'd0, 32'h0000_0403);
    rd_reg(2'd0, rv); check("R11 mode write", rv, 32'h0000_0403);
    wr_reg(2'd1, 32'hFFFF_FFFF);
    for (int i = 0; i < 4; i++) load_rx(8'hC0 + 8'(i));
    idle(2);
    rd_reg(2'd1, rv); check("R6 rx threshold set", {31'h0, rv[13]}, 32'h1);
    read_rx("R3 rx word two", 2'd2);
    idle(2);
    rd_reg(2'd1, rv); check("R6 rx threshold sticky", {31'h0, rv[13]}, 32'h1);
    wr_reg(2'd1, 32'h0000_2000);
    rd_reg(2'd1, rv); check("R7 rx threshold cleared", {31'h0, rv[13]}, 32'h0);

    pulse_done();
    rd_reg(2'd1, rv); check("R6 done set", {31'h0, rv[14]}, 32'h1);
    wr_reg(2'd1, 32'h0000_0000);
    rd_reg(2'd1, rv); check("R7 zero write keeps done", {31'h0, rv[14]}, 32'h1);
    wr_reg(2'd1, 32'hFFFF_FFFF);
    rd_reg(2'd1, rv);
    check("R7 all ones clears", {29'h0, rv[14:12]}, 32'h0);
    check("R6 tx threshold set wins", {31'h0, rv[11]}, 32'h1);

    for (int i = 0; i < 33; i++) load_rx(8'(i * 7));
    idle(2);
    rd_reg(2'd1, rv);
    check("R6 rx full set", {31'h0, rv[12]}, 32'h1);
    check("R9 rx full count", {26'h0, rv[29:24]}, 32'd32);
    for (int i = 0; i < 8; i++) read_rx("R9 rx overflow dropped", 2'd2);
    idle(2);
    rd_reg(2'd1, rv); check("R6 rx full sticky", {31'h0, rv[12]}, 32'h1);
    wr_reg(2'd1, 32'h0000_1000);
    rd_reg(2'd1, rv); check("R7 rx full cleared", {31'h0, rv[12]}, 32'h0);

    @(negedge clk) check("R8 no mask irq low", {31'h0, irq}, 32'h0);
    wr_reg(2'd2, 32'hFFFF_FFFF);
    rd_reg(2'd2, rv); check("R8 mask readback", rv, 32'h0000_FB00);
    wr_reg(2'd2, 32'h0000_0800);
    @(negedge clk) check("R8 irq tx threshold", {31'h0, irq}, 32'h1);
    wr_reg(2'd2, 32'h0000_4000);
    @(negedge clk) check("R8 irq done masked off", {31'h0, irq}, 32'h0);
    pulse_done();
    @(negedge clk) check("R8 irq done", {31'h0, irq}, 32'h1);
    wr_reg(2'd1, 32'h0000_4000);
    @(negedge clk) check("R8 irq after clear", {31'h0, irq}, 32'h0);
    wr_reg(2'd2, 32'h0000_0100);
    @(negedge clk) check("R8 irq live flag", {31'h0, irq}, 32'h1);

    wr_reg(2'd0, 32'h0000_000F);
    wr_reg(2'd1, 32'h0000_0800);
    idle(2);
    rd_reg(2'd1, rv); check("R11 tx threshold zero", {31'h0, rv[11]}, 32'h0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule